// File: doc/BRIEF.md
# Look-up Table Stuck-At Fault Vector Generator

The block takes the 16-entry truth table of a 4-input look-up table and works out which of the four inputs really change the output. From that it lists every single stuck-at fault on the output and on each input that matters. For each fault it gives the altered truth table that models that fault. Faults whose altered tables are bit-for-bit equal count as equivalent, and the block gives each fault the index of its equivalence class.

A host loads a table with a one-cycle `start_i` while the block is idle. The block then streams one fault record per accepted cycle over a valid/ready handshake. Each record carries the altered table, a fault identifier, the class index and a flag that marks the first member of a class. When the last record has been taken, a one-cycle `done_o` reports the raw fault count and the collapsed (class) count. The active-input mask and the table type (the number of active inputs) stay on the ports from the load until the next load.

Top module: `lut_fault_gen`

## Requirements
- R1: `table_i[n]` is the output for the input value n, where bit k of n is input ik. Bit x of `active_o` is 0 exactly when `table[n] == table[n ^ (1<<x)]` for every n.
- R2: `type_o` equals the number of set bits in `active_o` (0 to 4).
- R3: Records come out in a fixed order of fault identifiers. Identifier 2*s+v means stuck-at-v on site s. Site 0 is the output and sites 1, 2, 3, 4 are inputs i3, i2, i1, i0. Faults on inactive inputs are skipped.
- R4: The fault table for the output stuck at v has all 16 bits equal to v.
- R5: The fault table for input ix stuck at v has, at each position n, the value `table[n']`, where n' is n with bit x forced to v.
- R6: A fault takes the class index of the earlier class whose fault table equals its own. If there is no such class, it takes the next unused index, counting from 0. `rec_first_o` is 1 exactly for the fault that opens a new class.
- R7: The first record is valid in the cycle after `start_i` is accepted. A record is held unchanged while `rec_ready_i` is low. Each cycle with valid and ready both high moves on to the next record.
- R8: `done_o` is high for exactly one cycle, the cycle after the last record is accepted. In that cycle `total_cnt_o` = 2*(`type_o`+1) and `coll_cnt_o` = the number of classes. For the table 16'hF888 the counts are 10 and 8.
- R9: `start_i` and `table_i` are ignored while records are streaming and in the `done_o` cycle.
- R10: After reset, `rec_valid_o` and `done_o` are 0, and `active_o` and `type_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load `table_i` and begin, taken only when idle |
| table_i | input | 16 | Truth table to analyse |
| active_o | output | 4 | Active-input mask, bit x for input ix |
| type_o | output | 3 | Number of active inputs |
| rec_valid_o | output | 1 | Fault record valid |
| rec_ready_i | input | 1 | Consumer accepts record |
| rec_table_o | output | 16 | Fault truth table |
| rec_id_o | output | 4 | Fault identifier, 2*site+stuck value |
| rec_class_o | output | 4 | Equivalence class index |
| rec_first_o | output | 1 | Record opens a new class |
| done_o | output | 1 | One-cycle end-of-list pulse |
| total_cnt_o | output | 4 | Uncollapsed fault count |
| coll_cnt_o | output | 4 | Collapsed fault count |

## Verification
The hardest cases to reach are class merges across different fault sites. Examples are an input stuck-at matching the output stuck-at, or two inputs stuck at 0 giving the same table. Input order matters here, because the class index must point back to the earliest class. The stimulus therefore uses structured tables alongside random ones: AND of all inputs, a sum of products, a parity function, a single-input table and constant tables. It also throttles ready in several patterns, so merges are seen while a record is being held. Separate runs pulse `start_i` with a different table in the middle of a stream and in the done cycle.

// File: rtl/lfg_pkg.sv
package lfg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } lfg_state_e;
endpackage

// File: rtl/lfg_relevance.sv
module lfg_relevance #(
  parameter int N_IN = 4,
  localparam int TW  = 1 << N_IN,
  localparam int TYW = $clog2(N_IN + 1)
) (
  input  logic [TW-1:0]   tbl_i,
  output logic [N_IN-1:0] active_o,
  output logic [TYW-1:0]  type_o
);
  for (genvar x = 0; x < N_IN; x++) begin : g_in
    logic diff;
    always_comb begin
      diff = 1'b0;
      for (int p = 0; p < TW; p++) begin
        logic [N_IN-1:0] lo, hi;
        lo = N_IN'(p);
        hi = lo | (N_IN'(1) << x);
        if (!lo[x]) diff = diff | (tbl_i[lo] != tbl_i[hi]);
      end
    end
    assign active_o[x] = diff;
  end

  always_comb begin
    type_o = '0;
    for (int x = 0; x < N_IN; x++) type_o = type_o + TYW'(active_o[x]);
  end
endmodule

// File: rtl/lfg_fault_table.sv
module lfg_fault_table #(
  parameter int N_IN = 4,
  localparam int TW  = 1 << N_IN,
  localparam int SW  = $clog2(N_IN + 1)
) (
  input  logic [TW-1:0] tbl_i,
  input  logic [SW-1:0] site_i,
  input  logic          stuck_i,
  output logic [TW-1:0] ftbl_o
);
  logic [N_IN-1:0][TW-1:0] cand;

  // candidate per input: every position reads the cofactor selected by stuck_i
  for (genvar x = 0; x < N_IN; x++) begin : g_in
    logic [TW-1:0] ft;
    always_comb begin
      for (int p = 0; p < TW; p++) begin
        logic [N_IN-1:0] lo, src;
        lo  = N_IN'(p);
        src = stuck_i ? (lo | (N_IN'(1) << x)) : (lo & ~(N_IN'(1) << x));
        ft[p] = tbl_i[src];
      end
    end
    assign cand[x] = ft;
  end

  always_comb begin
    ftbl_o = {TW{stuck_i}};
    for (int x = 0; x < N_IN; x++)
      if (site_i == SW'(N_IN - x)) ftbl_o = cand[x];
  end
endmodule

// File: rtl/lfg_class_match.sv
module lfg_class_match #(
  parameter int N_IN = 4,
  localparam int TW   = 1 << N_IN,
  localparam int NF   = 2 * (N_IN + 1),
  localparam int CNTW = $clog2(NF + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            wr_i,
  input  logic [TW-1:0]   cand_i,
  output logic [CNTW-1:0] cls_o,
  output logic            new_o,
  output logic [CNTW-1:0] ncls_o
);
  logic [NF-1:0][TW-1:0] store_q;
  logic [CNTW-1:0]       ncls_q;

  // classes hold distinct tables, so at most one entry matches
  always_comb begin
    new_o = 1'b1;
    cls_o = ncls_q;
    for (int c = NF - 1; c >= 0; c--) begin
      if (CNTW'(c) < ncls_q && store_q[c] == cand_i) begin
        new_o = 1'b0;
        cls_o = CNTW'(c);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q <= '0;
      ncls_q  <= '0;
    end else if (clear_i) begin
      ncls_q <= '0;
    end else if (wr_i && new_o) begin
      for (int c = 0; c < NF; c++)
        if (ncls_q == CNTW'(c)) store_q[c] <= cand_i;
      ncls_q <= ncls_q + 1'b1;
    end
  end

  assign ncls_o = ncls_q;
endmodule

// File: rtl/lut_fault_gen.sv
module lut_fault_gen #(
  parameter int N_IN = 4,
  localparam int TW   = 1 << N_IN,
  localparam int SW   = $clog2(N_IN + 1),
  localparam int IDW  = SW + 1,
  localparam int NF   = 2 * (N_IN + 1),
  localparam int CNTW = $clog2(NF + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [TW-1:0]   table_i,
  output logic [N_IN-1:0] active_o,
  output logic [SW-1:0]   type_o,
  output logic            rec_valid_o,
  input  logic            rec_ready_i,
  output logic [TW-1:0]   rec_table_o,
  output logic [IDW-1:0]  rec_id_o,
  output logic [CNTW-1:0] rec_class_o,
  output logic            rec_first_o,
  output logic            done_o,
  output logic [CNTW-1:0] total_cnt_o,
  output logic [CNTW-1:0] coll_cnt_o
);
  import lfg_pkg::*;

  lfg_state_e    state_q;
  logic [TW-1:0] tbl_q;
  logic [SW-1:0] site_q;
  logic          stuck_q;
  logic          fire, load;
  logic          nxt_found;
  logic [SW-1:0] nxt_site;
  logic          cls_new;

  assign load = (state_q == ST_IDLE) && start_i;
  assign fire = rec_valid_o && rec_ready_i;

  lfg_relevance #(.N_IN(N_IN)) i_rel (
    .tbl_i   (tbl_q),
    .active_o(active_o),
    .type_o  (type_o)
  );

  lfg_fault_table #(.N_IN(N_IN)) i_ftab (
    .tbl_i  (tbl_q),
    .site_i (site_q),
    .stuck_i(stuck_q),
    .ftbl_o (rec_table_o)
  );

  lfg_class_match #(.N_IN(N_IN)) i_cls (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(load),
    .wr_i   (fire),
    .cand_i (rec_table_o),
    .cls_o  (rec_class_o),
    .new_o  (cls_new),
    .ncls_o (coll_cnt_o)
  );

  // nearest later site that is an active input; descending loop keeps the lowest
  always_comb begin
    nxt_found = 1'b0;
    nxt_site  = site_q;
    for (int s = N_IN; s >= 1; s--) begin
      if (SW'(s) > site_q && active_o[N_IN-s]) begin
        nxt_found = 1'b1;
        nxt_site  = SW'(s);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tbl_q   <= '0;
      site_q  <= '0;
      stuck_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          tbl_q   <= table_i;
          site_q  <= '0;
          stuck_q <= 1'b0;
          state_q <= ST_RUN;
        end
        ST_RUN: if (fire) begin
          if (!stuck_q) begin
            stuck_q <= 1'b1;
          end else if (nxt_found) begin
            site_q  <= nxt_site;
            stuck_q <= 1'b0;
          end else begin
            state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rec_valid_o = (state_q == ST_RUN);
  assign rec_id_o    = {site_q, stuck_q};
  assign rec_first_o = cls_new;
  assign done_o      = (state_q == ST_DONE);
  assign total_cnt_o = CNTW'(2 * (int'(type_o) + 1));
endmodule

// File: rtl/lfg_checker.sv
module lfg_checker #(
  parameter int N_IN = 4,
  localparam int TW   = 1 << N_IN,
  localparam int SW   = $clog2(N_IN + 1),
  localparam int IDW  = SW + 1,
  localparam int NF   = 2 * (N_IN + 1),
  localparam int CNTW = $clog2(NF + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_IN-1:0] active_o,
  input logic            rec_valid_o,
  input logic            rec_ready_i,
  input logic [TW-1:0]   rec_table_o,
  input logic [IDW-1:0]  rec_id_o,
  input logic [CNTW-1:0] rec_class_o,
  input logic            rec_first_o,
  input logic            done_o,
  input logic [CNTW-1:0] total_cnt_o,
  input logic [CNTW-1:0] coll_cnt_o
);
  logic [CNTW-1:0] recs_q, firsts_q;
  logic [SW-1:0]   site;
  logic            site_ok;

  assign site = rec_id_o[IDW-1:1];

  always_comb begin
    site_ok = (site == '0);
    for (int x = 0; x < N_IN; x++)
      if (site == SW'(N_IN - x)) site_ok = active_o[x];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      recs_q   <= '0;
      firsts_q <= '0;
    end else if (done_o) begin
      recs_q   <= '0;
      firsts_q <= '0;
    end else if (rec_valid_o && rec_ready_i) begin
      recs_q   <= recs_q + 1'b1;
      firsts_q <= firsts_q + CNTW'(rec_first_o);
    end
  end

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_table_o)
      && $stable(rec_id_o) && $stable(rec_class_o) && $stable(rec_first_o));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rec_valid_o);

  p_rec_total_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> recs_q == total_cnt_o && firsts_q == coll_cnt_o);

  p_site_active_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> site_ok && rec_id_o < IDW'(NF));

  p_new_class_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_first_o |-> rec_class_o == firsts_q);

  p_old_class_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_first_o |-> rec_class_o < firsts_q);

  p_out_stuck_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && site == '0 |-> rec_table_o == {TW{rec_id_o[0]}});
endmodule

bind lut_fault_gen lfg_checker #(.N_IN(N_IN)) i_lfg_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .active_o   (active_o),
  .rec_valid_o(rec_valid_o),
  .rec_ready_i(rec_ready_i),
  .rec_table_o(rec_table_o),
  .rec_id_o   (rec_id_o),
  .rec_class_o(rec_class_o),
  .rec_first_o(rec_first_o),
  .done_o     (done_o),
  .total_cnt_o(total_cnt_o),
  .coll_cnt_o (coll_cnt_o)
);

// File: tb/test_lut_fault_gen.sv
module test_lut_fault_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] table_i = '0;
  logic [3:0]  active_o;
  logic [2:0]  type_o;
  logic        rec_valid_o;
  logic        rec_ready_i = 1'b0;
  logic [15:0] rec_table_o;
  logic [3:0]  rec_id_o;
  logic [3:0]  rec_class_o;
  logic        rec_first_o;
  logic        done_o;
  logic [3:0]  total_cnt_o;
  logic [3:0]  coll_cnt_o;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  int q_tbl[$], q_id[$], q_cls[$], q_first[$];
  int exp_mask, exp_type, exp_total, exp_coll;

  always #4 clk_i = ~clk_i;

  lut_fault_gen i_lut_fault_gen (.*);

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic build(input logic [15:0] t);
    logic [15:0] reps[$];
    q_tbl.delete(); q_id.delete(); q_cls.delete(); q_first.delete();
    exp_mask = 0; exp_type = 0;
    for (int x = 0; x < 4; x++) begin
      for (int n = 0; n < 16; n++)
        if (t[n] != t[n ^ (1 << x)]) exp_mask |= (1 << x);
      if (exp_mask[x]) exp_type++;
    end
    for (int s = 0; s <= 4; s++) begin
      if (s > 0 && !exp_mask[4-s]) continue;
      for (int v = 0; v < 2; v++) begin
        logic [15:0] ft;
        int cls;
        if (s == 0) ft = v ? 16'hFFFF : 16'h0000;
        else for (int n = 0; n < 16; n++)
          ft[n] = t[v ? (n | (1 << (4 - s))) : (n & ~(1 << (4 - s)))];
        cls = -1;
        foreach (reps[k]) if (cls < 0 && reps[k] == ft) cls = k;
        q_first.push_back(cls < 0);
        if (cls < 0) begin cls = reps.size(); reps.push_back(ft); end
        q_tbl.push_back(ft); q_id.push_back(2 * s + v); q_cls.push_back(cls);
      end
    end
    exp_total = q_tbl.size();
    exp_coll  = reps.size();
  endtask

  // mode 0: always ready, 1: random, 2: ready one cycle in three
  task automatic run_case(input logic [15:0] t, input int mode, input bit disturb);
    int cyc = 0;
    build(t);
    @(negedge clk_i); start_i = 1'b1; table_i = t;
    @(negedge clk_i); start_i = 1'b0;
    while (q_tbl.size() > 0) begin
      check("R7 valid", rec_valid_o, 1);
      check("R4/R5 table", rec_table_o, q_tbl[0]);
      check("R3 id", rec_id_o, q_id[0]);
      check("R6 class", rec_class_o, q_cls[0]);
      check("R6 first", rec_first_o, q_first[0]);
      check("R8 no early done", done_o, 0);
      case (mode)
        0: rec_ready_i = 1'b1;
        1: rec_ready_i = 1'($urandom_range(0, 1));
        default: rec_ready_i = (cyc % 3 == 2);
      endcase
      if (disturb && cyc == 0) begin start_i = 1'b1; table_i = ~t; end  // R9
      else start_i = 1'b0;
      @(posedge clk_i);
      if (rec_ready_i) begin
        void'(q_tbl.pop_front()); void'(q_id.pop_front());
        void'(q_cls.pop_front()); void'(q_first.pop_front());
      end
      @(negedge clk_i);
      cyc++;
    end
    rec_ready_i = 1'b0;
    check("R8 done", done_o, 1);
    check("R8 stream ended", rec_valid_o, 0);
    check("R8 total", total_cnt_o, exp_total);
    check("R8 collapsed", coll_cnt_o, exp_coll);
    check("R1 mask", active_o, exp_mask);
    check("R2 type", type_o, exp_type);
    if (disturb) begin start_i = 1'b1; table_i = ~t; end  // R9 in done cycle
    @(negedge clk_i);
    start_i = 1'b0;
    check("R8 done pulse", done_o, 0);
    check("R9 start in done ignored", rec_valid_o, 0);
    check("R9 mask kept", active_o, exp_mask);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10 valid", rec_valid_o, 0);
    check("R10 done", done_o, 0);
    check("R10 mask", active_o, 0);
    check("R10 type", type_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 idle valid", rec_valid_o, 0);

    run_case(16'hF888, 0, 0);
    check("R8 F888 collapsed", coll_cnt_o, 8);
    check("R8 F888 total", total_cnt_o, 10);
    run_case(16'h0000, 0, 0);
    run_case(16'hFFFF, 1, 0);
    run_case(16'h8000, 2, 0);
    run_case(16'hAAAA, 1, 0);
    run_case(16'h6996, 2, 0);
    run_case(16'hF888, 1, 1);
    run_case(16'h00F0, 0, 1);
    for (int i = 0; i < 12; i++) run_case(16'($urandom), i % 3, i[0]);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule